// File: doc/BRIEF.md
# Interrupt Acceptance and Idle Controller

This block sits beside a small 8-bit microcontroller core. It decides at each instruction boundary whether a pending interrupt may be vectored, and it handles the low-power idle state. The core reports instruction completion together with three qualifiers: the instruction was a return-from-interrupt, it wrote the enable or priority register, or it set the idle bit of the power-control register. The controller answers with a one-cycle vector request that carries the winning source index and level. It also drives an idle flag that gates the CPU clock and a wake pulse.

Request lines are captured every cycle into pending latches, so a short event that arrives while vectoring is blocked is not lost. Two acceptance levels exist, each with its own in-service flag. A source is accepted only when the global enable and its own enable bit are both set. The control sequencer has three named states. ST_RUN is normal execution. ST_HOLD is entered after a blocking instruction, and the next boundary must pass before a vector may be taken. ST_IDLE means the clock is gated. The transitions are: run/hold to idle on an idle-bit write; run/hold to hold on a return or an enable/priority write; hold or run to run on any other boundary, vectoring if a source is acceptable; idle to run when an acceptable source is pending, which is the wake transition.

Top module: `irq_gate_ctrl`

## Requirements
- R1: A synchronous reset clears all pending, in-service and idle state. After reset `vec_req`, `wake` and `cpu_idle` are 0, and a boundary with nothing requested after reset produces no vector.
- R2: At a boundary where the completed instruction is a return-from-interrupt, no vector is issued, even when an acceptable source is pending.
- R3: At a boundary where the completed instruction wrote the enable or priority register, no vector is issued. The vector can come no earlier than the next boundary whose instruction is not blocking.
- R4: A source is accepted only when `ie_global` and that source's bit in `ie_src_en` are both 1. A disabled source stays pending and is vectored once both are set.
- R5: A request that is high for a single cycle sets a pending latch. The latch holds until that source is vectored.
- R6: A source whose `ip_hi` bit is 1 beats every source whose bit is 0. Within a level, the lowest index wins.
- R7: While a level is in service, a source of the same or a lower level is not vectored, but a high-level source may preempt a low level in service. A return clears only the highest in-service level.
- R8: At a boundary with `instr_set_idle`, no vector is issued and `cpu_idle` is 1 in the following cycle. Idle stays set while no acceptable source is pending, and boundary inputs are ignored while idle.
- R9: While idle, an acceptable pending source ends idle. `cpu_idle` falls in the same cycle that `vec_req` and `wake` are 1.
- R10: An enable write that sets `ie_global`, followed at the next boundary by the idle-bit write, issues no vector at either boundary. Idle is entered for exactly one cycle and then ends with the vector for the pending source.
- R11: A vector request is a one-cycle pulse in the cycle after the deciding boundary (or after the wake decision). It clears the vectored source's pending latch, so a later boundary issues no second vector for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock (ungated) |
| rst | input | 1 | Synchronous reset, active high |
| irq_req | input | NUM_SRC | Raw interrupt request lines, bit i is source i |
| ie_src_en | input | NUM_SRC | Per-source enable bits |
| ie_global | input | 1 | Global interrupt enable |
| ip_hi | input | NUM_SRC | Per-source level, 1 = high |
| instr_done | input | 1 | An instruction completed this cycle |
| instr_reti | input | 1 | Completed instruction was a return-from-interrupt |
| instr_wr_ie_ip | input | 1 | Completed instruction wrote the enable or priority register |
| instr_set_idle | input | 1 | Completed instruction set the idle bit |
| vec_req | output | 1 | One-cycle vector request |
| vec_idx | output | IDX_W | Index of the vectored source |
| vec_hi | output | 1 | Level of the vectored source |
| cpu_idle | output | 1 | CPU clock gate, 1 = clock stopped |
| wake | output | 1 | Pulse marking the end of idle |

## Verification
The hardest case to reach is the race between enabling and sleeping. The global enable must rise at the very boundary where vectoring is blocked, and the idle write must land at the next boundary while the source is already latched. The bench first leaves a source pending with the global enable low. It then raises the enable in the same cycle as a blocked enable-register boundary and issues the idle boundary directly after it. Finally it samples the single idle cycle and the wake cycle one by one. Nested service is reached in a similar way: a high-level source is pulsed while a low level is in service, and the bench then shows that one return releases only the high level.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_HOLD = 2'd1,
        ST_IDLE = 2'd2
    } ctl_state_e;

    typedef struct packed {
        logic is_boundary;
        logic is_blocking;
        logic is_sleep;
        logic is_return;
    } instr_info_t;

endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
    parameter int NUM_SRC = 5,
    parameter int IDX_W   = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] req,
    input  logic               clr_vld,
    input  logic [IDX_W-1:0]   clr_idx,
    output logic [NUM_SRC-1:0] pend
);

    logic [NUM_SRC-1:0] clr_mask;

    // One clear-mask bit per source
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_mask
        assign clr_mask[g] = clr_vld && (clr_idx == IDX_W'(g));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
        end else begin
            pend <= (pend & ~clr_mask) | req;
        end
    end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int NUM_SRC = 5,
    parameter int IDX_W   = 3
) (
    input  logic [NUM_SRC-1:0] pend,
    input  logic [NUM_SRC-1:0] src_en,
    input  logic               ea,
    input  logic [NUM_SRC-1:0] ip_hi,
    input  logic               svc_hi,
    input  logic               svc_lo,
    output logic               take_vld,
    output logic [IDX_W-1:0]   take_idx,
    output logic               take_hi
);

    logic [NUM_SRC-1:0] elig;
    logic [NUM_SRC-1:0] hi_ok;
    logic [NUM_SRC-1:0] lo_ok;
    logic [NUM_SRC-1:0] sel;
    logic [NUM_SRC:0]   none_below;
    logic [NUM_SRC-1:0] first;

    assign elig  = pend & src_en & {NUM_SRC{ea}};
    assign hi_ok = svc_hi ? '0 : (elig & ip_hi);
    assign lo_ok = (svc_hi || svc_lo) ? '0 : (elig & ~ip_hi);

    assign take_hi  = |hi_ok;
    assign sel      = take_hi ? hi_ok : lo_ok;
    assign take_vld = |sel;

    // Lowest-index-first chain over the selected level
    assign none_below[0] = 1'b1;
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_first
        assign first[g]        = sel[g] && none_below[g];
        assign none_below[g+1] = none_below[g] && !sel[g];
    end

    always_comb begin
        take_idx = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (first[i]) begin
                take_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/irq_svc_track.sv
module irq_svc_track (
    input  logic clk,
    input  logic rst,
    input  logic set_vld,
    input  logic set_hi,
    input  logic pop,
    output logic svc_hi,
    output logic svc_lo
);

    always_ff @(posedge clk) begin
        if (rst) begin
            svc_hi <= 1'b0;
            svc_lo <= 1'b0;
        end else if (set_vld) begin
            if (set_hi) begin
                svc_hi <= 1'b1;
            end else begin
                svc_lo <= 1'b1;
            end
        end else if (pop) begin
            if (svc_hi) begin
                svc_hi <= 1'b0;
            end else begin
                svc_lo <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/irq_gate_ctrl.sv
module irq_gate_ctrl
    import irq_ctl_pkg::*;
#(
    parameter int NUM_SRC = 5,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic [NUM_SRC-1:0] ie_src_en,
    input  logic               ie_global,
    input  logic [NUM_SRC-1:0] ip_hi,
    input  logic               instr_done,
    input  logic               instr_reti,
    input  logic               instr_wr_ie_ip,
    input  logic               instr_set_idle,
    output logic               vec_req,
    output logic [IDX_W-1:0]   vec_idx,
    output logic               vec_hi,
    output logic               cpu_idle,
    output logic               wake
);

    ctl_state_e         state_q;
    ctl_state_e         state_d;
    instr_info_t        info;
    logic [NUM_SRC-1:0] pend;
    logic               svc_hi;
    logic               svc_lo;
    logic               take_vld;
    logic [IDX_W-1:0]   take_idx;
    logic               take_hi;
    logic               fire;
    logic               fire_wake;
    logic               pop;

    assign info.is_boundary = instr_done;
    assign info.is_blocking = instr_reti || instr_wr_ie_ip;
    assign info.is_sleep    = instr_set_idle;
    assign info.is_return   = instr_reti;

    irq_pend_bank #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_pend (
        .clk     (clk),
        .rst     (rst),
        .req     (irq_req),
        .clr_vld (fire),
        .clr_idx (take_idx),
        .pend    (pend)
    );

    irq_prio_pick #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_pick (
        .pend     (pend),
        .src_en   (ie_src_en),
        .ea       (ie_global),
        .ip_hi    (ip_hi),
        .svc_hi   (svc_hi),
        .svc_lo   (svc_lo),
        .take_vld (take_vld),
        .take_idx (take_idx),
        .take_hi  (take_hi)
    );

    irq_svc_track u_svc (
        .clk     (clk),
        .rst     (rst),
        .set_vld (fire),
        .set_hi  (take_hi),
        .pop     (pop),
        .svc_hi  (svc_hi),
        .svc_lo  (svc_lo)
    );

    // Next-state and decision logic
    always_comb begin
        state_d   = state_q;
        fire      = 1'b0;
        fire_wake = 1'b0;
        pop       = 1'b0;
        unique case (state_q)
            ST_RUN, ST_HOLD: begin
                if (info.is_boundary) begin
                    pop = info.is_return;
                    if (info.is_sleep) begin
                        state_d = ST_IDLE;
                    end else if (info.is_blocking) begin
                        state_d = ST_HOLD;
                    end else begin
                        state_d = ST_RUN;
                        fire    = take_vld;
                    end
                end
            end
            ST_IDLE: begin
                if (take_vld) begin
                    state_d   = ST_RUN;
                    fire      = 1'b1;
                    fire_wake = 1'b1;
                end
            end
            default: state_d = ST_RUN;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            vec_req  <= 1'b0;
            vec_idx  <= '0;
            vec_hi   <= 1'b0;
            cpu_idle <= 1'b0;
            wake     <= 1'b0;
        end else begin
            vec_req  <= fire;
            wake     <= fire_wake;
            cpu_idle <= (state_d == ST_IDLE);
            if (fire) begin
                vec_idx <= take_idx;
                vec_hi  <= take_hi;
            end
        end
    end

endmodule

// File: rtl/irq_gate_ctrl_chk.sv
module irq_gate_ctrl_chk #(
    parameter int NUM_SRC = 5,
    parameter int IDX_W   = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             ie_global,
    input logic             instr_done,
    input logic             instr_reti,
    input logic             instr_wr_ie_ip,
    input logic             instr_set_idle,
    input logic             vec_req,
    input logic [IDX_W-1:0] vec_idx,
    input logic             cpu_idle,
    input logic             wake
);

    AST_RETI_NO_VEC: assert property (@(posedge clk) disable iff (rst)
        (instr_done && instr_reti && !cpu_idle) |=> !vec_req); // R2

    AST_IEIP_NO_VEC: assert property (@(posedge clk) disable iff (rst)
        (instr_done && instr_wr_ie_ip && !cpu_idle) |=> !vec_req); // R3

    AST_EA_NEEDED: assert property (@(posedge clk) disable iff (rst)
        vec_req |-> $past(ie_global)); // R4

    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
        vec_req |-> (int'(vec_idx) < NUM_SRC)); // R6

    AST_IDLE_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (instr_done && instr_set_idle && !cpu_idle) |=> (cpu_idle && !vec_req)); // R8

    AST_WAKE_VEC: assert property (@(posedge clk) disable iff (rst)
        $fell(cpu_idle) |-> (vec_req && wake)); // R9

    AST_WAKE_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
        wake |-> $past(cpu_idle)); // R9

    AST_VEC_SOURCE: assert property (@(posedge clk) disable iff (rst)
        vec_req |-> ($past(instr_done) || $past(cpu_idle))); // R11

endmodule

bind irq_gate_ctrl irq_gate_ctrl_chk #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .ie_global      (ie_global),
    .instr_done     (instr_done),
    .instr_reti     (instr_reti),
    .instr_wr_ie_ip (instr_wr_ie_ip),
    .instr_set_idle (instr_set_idle),
    .vec_req        (vec_req),
    .vec_idx        (vec_idx),
    .cpu_idle       (cpu_idle),
    .wake           (wake)
);

// File: tb/sim_irq_gate_ctrl.sv
module sim_irq_gate_ctrl;

    localparam int N = 5;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] irq_req = '0;
    logic [N-1:0] ie_src_en = '0;
    logic         ie_global = 1'b0;
    logic [N-1:0] ip_hi = '0;
    logic         instr_done = 1'b0;
    logic         instr_reti = 1'b0;
    logic         instr_wr_ie_ip = 1'b0;
    logic         instr_set_idle = 1'b0;
    logic         vec_req;
    logic [2:0]   vec_idx;
    logic         vec_hi;
    logic         cpu_idle;
    logic         wake;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    irq_gate_ctrl #(.NUM_SRC(N)) u0 (
        .clk(clk), .rst(rst), .irq_req(irq_req), .ie_src_en(ie_src_en),
        .ie_global(ie_global), .ip_hi(ip_hi), .instr_done(instr_done),
        .instr_reti(instr_reti), .instr_wr_ie_ip(instr_wr_ie_ip),
        .instr_set_idle(instr_set_idle), .vec_req(vec_req), .vec_idx(vec_idx),
        .vec_hi(vec_hi), .cpu_idle(cpu_idle), .wake(wake)
    );

    task automatic check(string req, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic pulse_irq(logic [N-1:0] m);
        irq_req = m;
        @(negedge clk);
        irq_req = '0;
    endtask

    task automatic boundary(bit r, bit w, bit s);
        instr_done = 1'b1; instr_reti = r; instr_wr_ie_ip = w; instr_set_idle = s;
        @(negedge clk);
        instr_done = 1'b0; instr_reti = 1'b0; instr_wr_ie_ip = 1'b0; instr_set_idle = 1'b0;
    endtask

    task automatic expect_vec(string req, int idx);
        check(req, vec_req, 1, "vec_req");
        check(req, vec_idx, idx, "vec_idx");
    endtask

    task automatic cleanup();
        boundary(1, 0, 0);
        boundary(1, 0, 0);
        boundary(0, 0, 0);
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1", vec_req, 0, "vec_req after reset");
        check("R1", cpu_idle, 0, "cpu_idle after reset");
        check("R1", wake, 0, "wake after reset");
        ie_global = 1'b1; ie_src_en = '1;
        boundary(0, 0, 0);
        check("R1", vec_req, 0, "no vector with nothing pending");
    endtask

    task automatic t_basic();
        pulse_irq(5'b00100);
        boundary(0, 0, 0);
        expect_vec("R5", 2);
        check("R11", vec_hi, 0, "level of vector");
        @(negedge clk);
        check("R11", vec_req, 0, "vector lasts one cycle");
        boundary(1, 0, 0);
        boundary(0, 0, 0);
        check("R11", vec_req, 0, "pending cleared by vector");
        @(negedge clk);
    endtask

    task automatic t_reti();
        pulse_irq(5'b00010);
        boundary(0, 0, 0);
        expect_vec("R7", 1);
        pulse_irq(5'b01000);
        boundary(0, 0, 0);
        check("R7", vec_req, 0, "same level blocked while in service");
        boundary(1, 0, 0);
        check("R2", vec_req, 0, "no vector at return boundary");
        boundary(0, 0, 0);
        expect_vec("R2", 3);
        cleanup();
    endtask

    task automatic t_ieip();
        pulse_irq(5'b00001);
        boundary(0, 1, 0);
        check("R3", vec_req, 0, "no vector after IE/IP write");
        boundary(0, 1, 0);
        check("R3", vec_req, 0, "no vector after second IE/IP write");
        boundary(0, 0, 0);
        expect_vec("R3", 0);
        cleanup();
    endtask

    task automatic t_enable();
        ie_global = 1'b0; ie_src_en = 5'b00001;
        pulse_irq(5'b00001);
        boundary(0, 0, 0);
        check("R4", vec_req, 0, "global enable low");
        ie_global = 1'b1; ie_src_en = 5'b00000;
        boundary(0, 0, 0);
        check("R4", vec_req, 0, "source enable low");
        ie_src_en = 5'b00001;
        boundary(0, 0, 0);
        expect_vec("R4", 0);
        cleanup();
        ie_src_en = '1;
    endtask

    task automatic t_prio();
        ip_hi = 5'b10000;
        pulse_irq(5'b11010);
        boundary(0, 0, 0);
        expect_vec("R6", 4);
        check("R6", vec_hi, 1, "high level taken");
        boundary(0, 0, 0);
        check("R7", vec_req, 0, "low blocked by high in service");
        boundary(1, 0, 0);
        boundary(0, 0, 0);
        expect_vec("R6", 1);
        pulse_irq(5'b10000);
        boundary(0, 0, 0);
        expect_vec("R7", 4);
        boundary(1, 0, 0);
        boundary(0, 0, 0);
        check("R7", vec_req, 0, "return cleared high only");
        boundary(1, 0, 0);
        boundary(0, 0, 0);
        expect_vec("R7", 3);
        cleanup();
        ip_hi = '0;
    endtask

    task automatic t_idle();
        boundary(0, 0, 1);
        check("R8", cpu_idle, 1, "idle entered");
        check("R8", vec_req, 0, "no vector at idle boundary");
        repeat (3) @(negedge clk);
        boundary(0, 0, 0);
        check("R8", cpu_idle, 1, "idle held, boundary ignored");
        check("R8", vec_req, 0, "no vector while idle");
        pulse_irq(5'b00100);
        check("R9", cpu_idle, 1, "idle before wake decision");
        @(negedge clk);
        check("R9", cpu_idle, 0, "idle released");
        check("R9", wake, 1, "wake pulse");
        expect_vec("R9", 2);
        @(negedge clk);
        check("R9", wake, 0, "wake one cycle");
        cleanup();
    endtask

    task automatic t_race();
        ie_global = 1'b0;
        pulse_irq(5'b00001);
        ie_global = 1'b1;
        boundary(0, 1, 0);
        check("R10", vec_req, 0, "no vector at enable write");
        check("R10", cpu_idle, 0, "not idle yet");
        boundary(0, 0, 1);
        check("R10", vec_req, 0, "no vector at idle write");
        check("R10", cpu_idle, 1, "idle entered");
        @(negedge clk);
        check("R10", cpu_idle, 0, "idle ends after one cycle");
        check("R10", wake, 1, "wake");
        expect_vec("R10", 0);
        cleanup();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_reti();
        t_ieip();
        t_enable();
        t_prio();
        t_idle();
        t_race();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule